// File: doc/BRIEF.md
# CPU Power-Down Request and WFI Forwarding

This block holds one software power-down request flag for each CPU of a four-CPU cluster and uses it to gate each CPU's wait-for-interrupt indication toward the power management unit. A CPU's WFI state is passed on only while software has asked for that CPU to be powered down. When a CPU reports WFI, the power management unit takes that as the point where the CPU can be shut off.

Software reaches the block through a small 32-bit register port. A word write to the control register replaces all request flags at once. Each request flag also drives a power status line toward an interrupt redirect block, which uses it to send interrupts away from a CPU that is being powered down. A second register reads back those status lines and is read-only. All outputs are registered. Each output changes at the first clock edge that samples the write or the input level causing the change.

Top module: `cpu_pd_wfi_ctrl`

## Requirements
- R1: The block serves four CPUs (NUM_CPU = 4). Each CPU has one request flag, one WFI input, one WFI output and one power status output, and the CPUs are handled identically and independently.
- R2: `wfi_out[i]` equals request flag i AND the sampled level of `wfi_in[i]`. It is registered, so it takes the new value at the clock edge that samples the write or the input change.
- R3: A word write (`reg_size` = 2'b10) to offset 0x90 replaces the request flags with `reg_wdata[3:0]`. Bits [31:4] of the written word are ignored.
- R4: `pwr_stat[i]` equals request flag i. It changes at the edge of a word write to 0x90 that changes that flag, and at no other time except reset. A write that leaves the flag unchanged leaves the line unchanged.
- R5: A change on `wfi_in[i]` affects only `wfi_out[i]`. The WFI outputs of the other CPUs stay unchanged.
- R6: While `rst_n` is low, all request flags and stored WFI levels are clear, and `wfi_out` and `pwr_stat` are all zero.
- R7: The status register at offset 0x94 reads `pwr_stat` in bits [3:0] and zero in bits [17:16] and in every other bit. Writes to it have no effect on any flag or output.
- R8: An access whose `reg_size` is not 2'b10 (2'b00 byte, 2'b01 half-word, 2'b11 reserved) is a no-op. Such a write changes nothing, and such a read returns zero.
- R9: `reg_rdata` is combinational and valid in the cycle in which `reg_rd` is high. A word read of 0x90 returns the request flags in [3:0] and zeros above them. A read of any other offset, or any cycle without `reg_rd`, returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe |
| reg_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data, little-endian word |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| wfi_in | input | 4 | Per-CPU wait-for-interrupt level |
| wfi_out | output | 4 | Per-CPU gated WFI toward the power management unit |
| pwr_stat | output | 4 | Per-CPU power-down status toward interrupt redirect |

## Verification
The assertions assume the register strobes and `wfi_in` are stable around the rising clock edge. They also assume that `reg_addr`, `reg_size` and `reg_wdata` are known whenever `reg_wr` is high, because otherwise the write-cause checks on `pwr_stat` would not be meaningful. The bench changes every input only on the falling edge. It raises a strobe for exactly one cycle per access and holds the register strobes low throughout reset. WFI levels are driven as whole 4-bit vectors, which lets a single-bit change be compared against the other three lanes.

// File: rtl/cpu_pd_pkg.sv
package cpu_pd_pkg;
   localparam int unsigned CTRL_OFS_DEF = 32'h90;
   localparam int unsigned STAT_OFS_DEF = 32'h94;
   localparam int unsigned STAT_HI_LSB  = 16;
   localparam int unsigned STAT_HI_W    = 2;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;
endpackage

// File: rtl/cpu_pd_regs.sv
module cpu_pd_regs
   import cpu_pd_pkg::*;
#(
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(CTRL_OFS_DEF),
   parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(STAT_OFS_DEF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               rd,
   input  logic [1:0]         size,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_CPU-1:0] stat_in,
   output logic [NUM_CPU-1:0] req_q,
   output logic [NUM_CPU-1:0] req_d,
   output logic [DATA_W-1:0]  rdata
);
   localparam int unsigned PAD_W = DATA_W - NUM_CPU;

   logic word_acc;
   logic ctrl_hit;
   logic stat_hit;

   assign word_acc = (acc_size_e'(size) == SZ_WORD);
   assign ctrl_hit = (addr == CTRL_OFS);
   assign stat_hit = (addr == STAT_OFS);

   always_comb begin
      req_d = req_q;
      if (wr && word_acc && ctrl_hit) begin
         req_d = wdata[NUM_CPU-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
      end else begin
         req_q <= req_d;
      end
   end

   // status word: low lanes carry the status lines, [17:16] are fixed zero
   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = {{PAD_W{1'b0}}, stat_in};
      stat_word[STAT_HI_LSB +: STAT_HI_W] = '0;
   end

   always_comb begin
      rdata = '0;
      if (rd && word_acc) begin
         if (ctrl_hit) begin
            rdata = {{PAD_W{1'b0}}, req_q};
         end else if (stat_hit) begin
            rdata = stat_word;
         end
      end
   end

   a_r8_narrow_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !word_acc) |=> $stable(req_q));
   a_r7_stat_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && stat_hit) |=> $stable(req_q));
   a_r9_idle_read_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (rdata == '0));
endmodule

// File: rtl/cpu_pd_lane.sv
module cpu_pd_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic req_cur,
   input  logic req_nxt,
   input  logic wfi_lvl,
   output logic wfi_gated,
   output logic stat
);
   logic wfi_q;
   logic gated_q;
   logic stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wfi_q   <= 1'b0;
         gated_q <= 1'b0;
         stat_q  <= 1'b0;
      end else begin
         wfi_q   <= wfi_lvl;
         gated_q <= req_nxt & wfi_lvl;
         if (req_nxt != req_cur) begin
            stat_q <= req_nxt;
         end
      end
   end

   assign wfi_gated = gated_q;
   assign stat      = stat_q;

   a_r2_wfi_passes : assert property (@(posedge clk) disable iff (!rst_n)
      (req_nxt && wfi_lvl) |=> wfi_gated);
   a_r2_wfi_blocked : assert property (@(posedge clk) disable iff (!rst_n)
      !req_cur |-> !wfi_gated);
   a_r2_wfi_low : assert property (@(posedge clk) disable iff (!rst_n)
      !wfi_q |-> !wfi_gated);
   a_r4_stat_tracks : assert property (@(posedge clk) disable iff (!rst_n)
      stat == req_cur);
endmodule

// File: rtl/cpu_pd_wfi_ctrl.sv
module cpu_pd_wfi_ctrl
   import cpu_pd_pkg::*;
#(
   parameter int unsigned NUM_CPU = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(CTRL_OFS_DEF),
   parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(STAT_OFS_DEF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [1:0]         reg_size,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_CPU-1:0] wfi_in,
   output logic [NUM_CPU-1:0] wfi_out,
   output logic [NUM_CPU-1:0] pwr_stat
);
   generate
      if (NUM_CPU != 4) begin : g_bad_cpu
         $error("cpu_pd_wfi_ctrl: NUM_CPU must be 4");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("cpu_pd_wfi_ctrl: only 32-bit register accesses are supported");
      end
      if (CTRL_OFS[1:0] != 2'b00 || STAT_OFS[1:0] != 2'b00 || CTRL_OFS == STAT_OFS) begin : g_bad_map
         $error("cpu_pd_wfi_ctrl: register offsets must be distinct and word aligned");
      end
   endgenerate

   logic [NUM_CPU-1:0] req_q;
   logic [NUM_CPU-1:0] req_d;

   cpu_pd_regs #(
      .NUM_CPU (NUM_CPU),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CTRL_OFS(CTRL_OFS),
      .STAT_OFS(STAT_OFS)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .rd     (reg_rd),
      .size   (reg_size),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .stat_in(pwr_stat),
      .req_q  (req_q),
      .req_d  (req_d),
      .rdata  (reg_rdata)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
      cpu_pd_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_cur  (req_q[c]),
         .req_nxt  (req_d[c]),
         .wfi_lvl  (wfi_in[c]),
         .wfi_gated(wfi_out[c]),
         .stat     (pwr_stat[c])
      );
   end

   logic ctrl_wr_strobe;
   assign ctrl_wr_strobe = reg_wr && (reg_size == 2'b10) && (reg_addr == CTRL_OFS);

   a_r4_stat_needs_write : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwr_stat) |-> $past(ctrl_wr_strobe));
   a_r6_reset_outputs : assert property (@(posedge clk)
      !rst_n |-> (wfi_out == '0 && pwr_stat == '0));
   a_r2_gate_subset : assert property (@(posedge clk) disable iff (!rst_n)
      (wfi_out & ~pwr_stat) == '0);
endmodule

// File: tb/cpu_pd_wfi_ctrl_test.sv
`timescale 1ns/1ps
module cpu_pd_wfi_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_size = 2'b10;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic [3:0]  wfi_in = 4'h0;
   logic [3:0]  wfi_out;
   logic [3:0]  pwr_stat;

   always #2.5 clk = ~clk;

   cpu_pd_wfi_ctrl uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_size (reg_size),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .wfi_in   (wfi_in),
      .wfi_out  (wfi_out),
      .pwr_stat (pwr_stat)
   );

   typedef struct {
      string       tag;
      int          sel;   // 0 wfi_out, 1 pwr_stat, 2 reg_rdata
      logic [31:0] exp;
   } item_t;

   item_t sb_q[$];
   event  sample_ev;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   // model state, built from the requirements
   logic [3:0] m_req = 4'h0;
   logic [3:0] m_wfi = 4'h0;

   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.sel)
               0:       act = {28'h0, wfi_out};
               1:       act = {28'h0, pwr_stat};
               default: act = reg_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(input string tag, input int sel, input logic [31:0] exp);
      item_t it;
      it.tag = tag; it.sel = sel; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic flush();
      ->sample_ev;
      #1;
   endtask

   task automatic expect_outputs(input string tag);
      push({tag, " wfi_out"}, 0, {28'h0, m_req & m_wfi});
      push({tag, " pwr_stat"}, 1, {28'h0, m_req});
      flush();
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
      @(negedge clk);
      reg_wr = 1'b0; reg_size = 2'b10;
      if (sz == 2'b10 && a == 8'h90) m_req = d[3:0];
   endtask

   task automatic reg_read(input logic [7:0] a, input logic [1:0] sz,
                           input string tag, input logic [31:0] exp);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a; reg_size = sz;
      #1;
      push(tag, 2, exp);
      flush();
      reg_rd = 1'b0; reg_size = 2'b10;
   endtask

   task automatic drive_wfi(input logic [3:0] v);
      @(negedge clk);
      wfi_in = v;
      @(negedge clk);
      m_wfi = v;
   endtask

   initial begin
      #20000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: outputs clear while reset is held
      push("R6 reset wfi_out", 0, 32'h0);
      push("R6 reset pwr_stat", 1, 32'h0);
      flush();
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(8'h90, 2'b10, "R9 ctrl after reset", 32'h0);
      reg_read(8'h94, 2'b10, "R7 stat after reset", 32'h0);

      // R2: WFI without a request is blocked
      drive_wfi(4'hF);
      expect_outputs("R2 no request");

      // R3: upper write bits ignored; R2/R4 follow
      reg_write(8'h90, 32'hFFFF_FFF5, 2'b10);
      expect_outputs("R3 R4 write 5");
      reg_read(8'h90, 2'b10, "R3 R9 ctrl readback", 32'h5);

      // R5: one input bit changes only its lane
      drive_wfi(4'hE);
      expect_outputs("R5 drop cpu0 wfi");
      drive_wfi(4'hA);
      expect_outputs("R5 drop cpu2 wfi");

      // R8: narrow accesses are no-ops
      reg_write(8'h90, 32'h0000_000F, 2'b00);
      reg_write(8'h90, 32'h0000_000F, 2'b01);
      reg_write(8'h90, 32'h0000_000F, 2'b11);
      expect_outputs("R8 narrow writes");
      reg_read(8'h90, 2'b00, "R8 byte read", 32'h0);
      reg_read(8'h90, 2'b01, "R8 half read", 32'h0);

      // R7: status register is read-only
      reg_write(8'h94, 32'hFFFF_FFFF, 2'b10);
      expect_outputs("R7 status write");
      reg_read(8'h94, 2'b10, "R7 status read", {28'h0, m_req});
      reg_read(8'h90, 2'b10, "R7 ctrl unchanged", {28'h0, m_req});

      // R1: all four lanes
      drive_wfi(4'hF);
      reg_write(8'h90, 32'h0000_000F, 2'b10);
      expect_outputs("R1 all lanes");
      reg_write(8'h90, 32'h0000_000A, 2'b10);
      expect_outputs("R1 R4 write A");
      reg_write(8'h90, 32'h0000_000A, 2'b10);
      expect_outputs("R4 same value");
      reg_read(8'h94, 2'b10, "R7 status A", 32'hA);

      // R9: unmapped offset reads zero
      reg_read(8'h40, 2'b10, "R9 unmapped", 32'h0);
      reg_write(8'h40, 32'h0000_0005, 2'b10);
      expect_outputs("R9 unmapped write");

      // R6: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      m_req = 4'h0;
      #1;
      push("R6 midrun wfi_out", 0, 32'h0);
      push("R6 midrun pwr_stat", 1, 32'h0);
      flush();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_outputs("R6 after release");
      reg_read(8'h90, 2'b10, "R6 ctrl cleared", 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule